// File: doc/BRIEF.md
# Adaptive F2F Bit Decoder

This block recovers data from a two-frequency (F2F, Aiken biphase) stream produced by a magnetic stripe read head after amplification and squaring. The line input is assumed already synchronized to the system clock. Every transition of the line is timed in ticks of a slow enable derived from the clock. Each cell always ends with a transition; a one-bit also carries an extra transition near its middle.

After reset the decoder waits out a settling period. It then watches for a card. The first transition opens the first cell. A selectable number of leading cells, four or eight, are treated as zero bits and are never reported. These leading cells teach the decoder the bit period. From then on, every cell is classified against 70% of the mean length of the two cells before it. The reference follows speed changes as the card is swiped.

Each decoded bit is reported with a one-cycle strobe, in true and inverted form. An active-low card-present output drops once the leading cells are consumed. It rises again when the line has been quiet long enough, and the decoder then waits for a fresh leading run.

Top module: `f2f_decoder`

## Requirements
- R1: While reset is low and right after it, `bit_stb` is 0, `card_n` is 1, `bit_val` is 0 and `bit_val_n` is 1.
- R2: For WAKE_TICKS ticks after reset is released, line transitions are ignored: no strobe, `card_n` stays 1, and no leading cell is counted.
- R3: With `lead_long` = 0 the first 4 cells after the opening transition are consumed; with `lead_long` = 1, 8 cells are consumed. None of them is strobed. `card_n` is still 1 just before the transition ending the last leading cell. It is 0 from the cycle after that transition.
- R4: In a data cell, if the first transition comes when the tick count since the cell start is at or above the threshold, the bit is 0. That same transition starts the next cell.
- R5: A first transition below the threshold is a mid-cell transition. The cell then ends as a 1 at the following transition.
- R6: A cell's length is the number of ticks from its opening transition to its closing one. A tick is one clock in every TICK_DIV. The threshold is floor(floor((a+b)/2)*7/10), where a and b are the two most recent cell lengths; the leading cells seed them. The counters saturate at 65535.
- R7: `bit_stb` is high for exactly one cycle, the cycle after the transition that ends a cell. `bit_val` holds the bit and `bit_val_n` is always its inverse.
- R8: With no line transition for TIMEOUT_TICKS ticks, `card_n` returns to 1 and the decoder restarts the count of leading cells, discarding any partial count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, starts the settling wait |
| lead_long | input | 1 | Leading cell count: 0 gives 4, 1 gives 8 |
| line_in | input | 1 | Synchronized F2F line |
| bit_stb | output | 1 | One-cycle strobe for a decoded bit |
| bit_val | output | 1 | Decoded bit, true polarity |
| bit_val_n | output | 1 | Decoded bit, inverted polarity |
| card_n | output | 1 | Low while a card is being decoded |

## Verification
The single-cycle strobe property depends on two cell-ending transitions never arriving on adjacent clocks. The cycle-count properties depend on the line changing only after the reset wait and a settling gap. The stimulus meets both. It keeps cells between 38 and 126 ticks, with at most 5% jitter and mid-cell transitions near the half point. This leaves a wide margin on either side of the 70% decision point. Only the directed threshold cases place a transition exactly at the threshold or one tick below it. `lead_long` changes only between cards, never while a card is being decoded.

// File: rtl/f2f_decoder.sv
module f2f_decoder #(
  parameter int TICK_DIV      = 125,
  parameter int WAKE_TICKS    = 10000,
  parameter int TIMEOUT_TICKS = 12500,
  parameter int CW            = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lead_long,
  input  logic line_in,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_val_n,
  output logic card_n
);
  localparam int TDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] CMAX   = '1;
  localparam logic [CW-1:0] WAKE_L = CW'(WAKE_TICKS);
  localparam logic [CW-1:0] TMO_L  = CW'(TIMEOUT_TICKS);

  typedef enum logic [1:0] {S_WAKE, S_LEAD, S_DATA} st_t;

  st_t           state_q;
  logic [TDW-1:0] div_q;
  logic          line_q, started_q, half_q;
  logic [CW-1:0] since_q, idle_q, h0_q, thr_q;
  logic [3:0]    lead_cnt;

  wire tick    = (div_q == TDW'(TICK_DIV - 1));
  wire edge_w  = line_in ^ line_q;
  wire timeout = (idle_q >= TMO_L);
  wire [3:0] lead_need = lead_long ? 4'd8 : 4'd4;
  wire [CW-1:0] tick_w = {{(CW-1){1'b0}}, tick};
  wire [CW-1:0] since_inc = (tick && since_q != CMAX) ? since_q + 1'b1 : since_q;
  wire [CW-1:0] idle_inc  = (tick && idle_q  != CMAX) ? idle_q  + 1'b1 : idle_q;

  assign bit_val_n = ~bit_val;

  function automatic logic [CW-1:0] thr_of(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0]   s;
    logic [CW+3:0] m;
    s = {1'b0, a} + {1'b0, b};
    m = ({3'b0, s[CW:1]} * (CW+3)'(7)) / (CW+3)'(10);
    return m[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_WAKE;
      div_q     <= '0;
      line_q    <= 1'b0;
      started_q <= 1'b0;
      half_q    <= 1'b0;
      since_q   <= '0;
      idle_q    <= '0;
      h0_q      <= '0;
      thr_q     <= '0;
      lead_cnt  <= '0;
      bit_stb   <= 1'b0;
      bit_val   <= 1'b0;
      card_n    <= 1'b1;
    end else begin
      div_q   <= tick ? '0 : div_q + 1'b1;
      line_q  <= line_in;
      bit_stb <= 1'b0;
      idle_q  <= edge_w ? tick_w : idle_inc;
      case (state_q)
        S_WAKE: begin
          since_q <= since_inc;
          if (since_q >= WAKE_L) begin
            state_q   <= S_LEAD;
            since_q   <= '0;
            started_q <= 1'b0;
            lead_cnt  <= '0;
          end
        end
        S_LEAD: begin
          if (edge_w) begin
            since_q   <= tick_w;
            started_q <= 1'b1;
            if (started_q) begin
              h0_q     <= since_q;
              lead_cnt <= 4'(lead_cnt + 4'd1);
              if (4'(lead_cnt + 4'd1) == lead_need) begin
                state_q <= S_DATA;
                card_n  <= 1'b0;
                half_q  <= 1'b0;
                thr_q   <= thr_of(since_q, h0_q);
              end
            end
          end else if (timeout) begin
            started_q <= 1'b0;
            lead_cnt  <= '0;
          end else begin
            since_q <= since_inc;
          end
        end
        S_DATA: begin
          if (edge_w) begin
            if (!half_q && since_q < thr_q) begin
              half_q  <= 1'b1;
              since_q <= since_inc;
            end else begin
              bit_stb <= 1'b1;
              bit_val <= half_q;
              half_q  <= 1'b0;
              since_q <= tick_w;
              h0_q    <= since_q;
              thr_q   <= thr_of(since_q, h0_q);
            end
          end else if (timeout) begin
            state_q   <= S_LEAD;
            card_n    <= 1'b1;
            started_q <= 1'b0;
            lead_cnt  <= '0;
            half_q    <= 1'b0;
          end else begin
            since_q <= since_inc;
          end
        end
        default: state_q <= S_WAKE;
      endcase
    end
  end

  assert_wake_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_WAKE |-> card_n && !bit_stb);

  assert_card_fall_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_n) |-> $past(edge_w) && state_q == S_DATA);

  assert_no_bits_before_card_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> !card_n);

  assert_counter_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_WAKE && since_q == CMAX && !edge_w) |=> since_q == CMAX);

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA && !edge_w && timeout) |=> card_n && state_q == S_LEAD);
endmodule

// File: tb/f2f_decoder_bench.sv
module f2f_decoder_bench;
  localparam int WAKE = 50;
  localparam int TMO  = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_long = 1'b0;
  logic line = 1'b0;
  logic bit_stb, bit_val, bit_val_n, card_n;

  int checks = 0;
  int errors = 0;
  bit got_q[$];
  bit exp_q[$];
  int ha = 0, hb = 0;
  bit await_high = 0, await_low = 0;
  logic prev_stb = 1'b0;

  always #4 clk = ~clk;

  f2f_decoder #(.TICK_DIV(1), .WAKE_TICKS(WAKE), .TIMEOUT_TICKS(TMO)) u_f2f_decoder (
    .clk(clk), .rst_n(rst_n), .lead_long(lead_long), .line_in(line),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_val_n(bit_val_n), .card_n(card_n));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_stb) begin
        got_q.push_back(bit_val);
        check(bit_val_n == ~bit_val, "R7 polarity", int'(bit_val_n), int'(~bit_val));
        check(!prev_stb, "R7 strobe width", int'(prev_stb), 0);
      end
      prev_stb <= bit_stb;
    end
  end

  function automatic int thr_now();
    return (((ha + hb) / 2) * 7) / 10;
  endfunction

  function automatic void push_len(int l);
    hb = ha;
    ha = l;
  endfunction

  task automatic gap(int n);
    repeat (n) @(negedge clk);
    if (await_high) begin
      check(card_n == 1'b1, "R3 card high before last lead edge", int'(card_n), 1);
      await_high = 0;
    end
    if (await_low) begin
      check(card_n == 1'b0, "R3 card low after lead", int'(card_n), 0);
      check(got_q.size() == 0, "R3 lead cells not strobed", got_q.size(), 0);
      await_low = 0;
    end
    line = ~line;
  endtask

  function automatic int jit_len(int d, int j);
    if (j == 0) return d;
    return d + int'($urandom % (2 * j + 1)) - j;
  endfunction

  task automatic lead(bit lng, int d, int j);
    int n;
    int l;
    lead_long = lng;
    n = lng ? 8 : 4;
    got_q.delete();
    exp_q.delete();
    gap(d);
    for (int i = 0; i < n; i++) begin
      l = jit_len(d, j);
      if (i == n - 1) await_high = 1;
      gap(l);
      push_len(l);
    end
    await_low = 1;
  endtask

  task automatic send_bit(bit b, int l);
    if (b) begin
      gap(l / 2);
      gap(l - l / 2);
    end else begin
      gap(l);
    end
    exp_q.push_back(b);
    push_len(l);
  endtask

  task automatic finish_card();
    repeat (3) @(negedge clk);
    check(got_q.size() == exp_q.size(), "R4/R5 bit count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      if (exp_q[i]) check(got_q[i] == exp_q[i], "R5 one bit", int'(got_q[i]), 1);
      else          check(got_q[i] == exp_q[i], "R4 zero bit", int'(got_q[i]), 0);
    end
    repeat (TMO - 10) @(negedge clk);
    check(card_n == 1'b0, "R8 card held before timeout", int'(card_n), 0);
    repeat (20) @(negedge clk);
    check(card_n == 1'b1, "R8 card released after timeout", int'(card_n), 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(bit_stb == 1'b0 && bit_val == 1'b0, "R1 reset outputs", int'(bit_stb), 0);
    check(card_n == 1'b1 && bit_val_n == 1'b1, "R1 reset status", int'(card_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(card_n == 1'b1 && bit_stb == 1'b0, "R1 after release", int'(card_n), 1);

    for (int i = 0; i < 5; i++) begin
      repeat (6) @(negedge clk);
      line = ~line;
    end
    repeat (40) @(negedge clk);
    check(card_n == 1'b1, "R2 wake ignores line", int'(card_n), 1);
    check(got_q.size() == 0, "R2 wake no strobes", got_q.size(), 0);

    lead(1'b0, 80, 0);
    send_bit(1'b1, 80); send_bit(1'b0, 80); send_bit(1'b0, 82); send_bit(1'b1, 78);
    finish_card();

    // R8: partial lead interrupted by timeout must not count
    lead_long = 1'b0;
    gap(80); gap(80); gap(80);
    repeat (TMO + 20) @(negedge clk);
    check(card_n == 1'b1, "R8 partial lead discarded", int'(card_n), 1);
    lead(1'b0, 90, 0);
    send_bit(1'b0, 90); send_bit(1'b1, 90); send_bit(1'b1, 90);
    finish_card();

    // R6 threshold boundary, directed
    begin
      int t;
      lead(1'b1, 100, 0);
      for (int k = 0; k < 3; k++) begin
        t = thr_now();
        gap(t - 1); gap(100 - (t - 1));
        exp_q.push_back(1'b1); push_len(100);
        t = thr_now();
        gap(t);
        exp_q.push_back(1'b0); push_len(t);
      end
      send_bit(1'b0, 100);
      repeat (3) @(negedge clk);
      check(got_q.size() == exp_q.size(), "R6 boundary count", got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
        check(got_q[i] == exp_q[i], "R6 threshold boundary bit", int'(got_q[i]), int'(exp_q[i]));
      exp_q.delete(); got_q.delete();
      repeat (TMO + 20) @(negedge clk);
      check(card_n == 1'b1, "R8 release after boundary card", int'(card_n), 1);
    end

    for (int c = 0; c < 8; c++) begin
      int d;
      int nb;
      d = 40 + int'($urandom % 81);
      nb = 10 + int'($urandom % 7);
      lead(bit'($urandom % 2), d, d / 20);
      for (int i = 0; i < nb; i++) send_bit(bit'($urandom % 2), jit_len(d, d / 20));
      finish_card();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule